// File: doc/BRIEF.md
# Clocked/Transparent Bus Holding Register

This block is the storage stage of one direction of a bus transceiver. Each bit pairs a level-sensitive path with an edge-triggered path. The data path is split into groups, and each group has its own latch enable, device clock and active-low output enable. With the latch enable high, the group is transparent. With it low, the group holds its value. While the latch enable is low, a rising edge on the device clock loads new data. The group's output enable drives a per-bit enable line that an external tristate driver uses.

Everything runs on one fast system clock. The device clock is sampled on that clock and its rising edge is detected, so the latch and the flop are both built from ordinary registers. The latch's level behaviour is emulated by reloading the stored value on every cycle the group is transparent. For a two-way transceiver, one instance serves each direction. Two nine-bit groups in one instance give an eighteen-bit path, and tying their controls together makes it one wide register.

Top module: `ubt_dir_reg`

## Requirements
- R1: While reset is low, every bit of `dout` and `drv_en` is 0, whatever the data input. Reset is asynchronous and clears every stored value to 0.
- R2: While a group's `latch_en` is 1 and its drive is on, that group's slice of `dout` equals its slice of `din` in the same cycle, with no register in the path.
- R3: While `latch_en` is 0 and no rising device-clock edge is seen, a group's output keeps its stored value. This holds whether `dev_clk` stays low or stays high, and whatever `din` does.
- R4: With `latch_en` at 0, a system-clock edge at which `dev_clk` is sampled 1, after being sampled 0 at the previous edge, stores `din`. The stored value appears on `dout` after that edge.
- R5: When `latch_en` falls, the stored value equals `din` from the last system cycle in which `latch_en` was 1.
- R6: A falling edge of the device clock stores nothing.
- R7: `drv_en` for a group becomes all ones one system cycle after its `oe_n` is sampled 0, and all zeros one cycle after `oe_n` is sampled 1. While drive is off, the group's `dout` bits are 0. Storage keeps working while drive is off, so a value loaded then shows once drive returns.
- R8: Group g owns bits [g*GROUP_W +: GROUP_W]. Its three controls affect only those bits.
- R9: If a device clock is already high when reset ends, it counts as no edge. Capture needs that clock to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples everything |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_clk | input | NUM_GROUPS | Per-group device clock; its rising edge loads data |
| latch_en | input | NUM_GROUPS | Per-group transparent enable, active high |
| oe_n | input | NUM_GROUPS | Per-group output enable, active low |
| din | input | GROUP_W*NUM_GROUPS | Data arriving from the source port |
| dout | output | GROUP_W*NUM_GROUPS | Data toward the far port; 0 while drive is off |
| drv_en | output | GROUP_W*NUM_GROUPS | Per-bit enable for the external tristate driver |

## Verification
The bench uses the default build of two nine-bit groups, which form the eighteen-bit path. The two groups are given different control patterns. This lets one group capture, hold or lose drive while the other stays unchanged, so group isolation can be seen at the ports. Holding one device clock high through reset makes the reset-edge corner reachable. The bench also loads data while drive is off and checks that it shows after drive returns.

// File: rtl/ubt_dir_reg.sv
module ubt_dir_reg #(
  parameter int GROUP_W    = 9,
  parameter int NUM_GROUPS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_GROUPS-1:0]         dev_clk,
  input  logic [NUM_GROUPS-1:0]         latch_en,
  input  logic [NUM_GROUPS-1:0]         oe_n,
  input  logic [GROUP_W*NUM_GROUPS-1:0] din,
  output logic [GROUP_W*NUM_GROUPS-1:0] dout,
  output logic [GROUP_W*NUM_GROUPS-1:0] drv_en
);
  localparam int W = GROUP_W * NUM_GROUPS;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gen_grp
    logic               clk_q;
    logic               en_q;
    logic [GROUP_W-1:0] held;
    logic               rise;

    // clk_q resets high so a clock already high at reset end is no edge
    assign rise = dev_clk[g] & ~clk_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        clk_q <= 1'b1;
        en_q  <= 1'b0;
        held  <= '0;
      end else begin
        clk_q <= dev_clk[g];
        en_q  <= ~oe_n[g];
        if (latch_en[g] || rise)
          held <= din[g*GROUP_W +: GROUP_W];
      end
    end

    assign dout[g*GROUP_W +: GROUP_W] =
      en_q ? (latch_en[g] ? din[g*GROUP_W +: GROUP_W] : held) : '0;
    assign drv_en[g*GROUP_W +: GROUP_W] = {GROUP_W{en_q}};
  end

  logic [W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/ubt_dir_reg_chk.sv
module ubt_dir_reg_chk #(
  parameter int GROUP_W    = 9,
  parameter int NUM_GROUPS = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_GROUPS-1:0]         dev_clk,
  input logic [NUM_GROUPS-1:0]         latch_en,
  input logic [NUM_GROUPS-1:0]         oe_n,
  input logic [GROUP_W*NUM_GROUPS-1:0] din,
  input logic [GROUP_W*NUM_GROUPS-1:0] dout,
  input logic [GROUP_W*NUM_GROUPS-1:0] drv_en
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gen_chk
    localparam int LO = g * GROUP_W;

    assert_drive_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n[g] |=> drv_en[LO +: GROUP_W] == {GROUP_W{1'b1}});

    assert_drive_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n[g] |=> (drv_en[LO +: GROUP_W] == '0 && dout[LO +: GROUP_W] == '0));

    assert_transparent_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en[g] && drv_en[LO]) |-> dout[LO +: GROUP_W] == din[LO +: GROUP_W]);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_en[g] && $past(!latch_en[g]) && !($past(dev_clk[g]) && !$past(dev_clk[g], 2))
       && drv_en[LO] && $past(drv_en[LO]))
      |-> dout[LO +: GROUP_W] == $past(dout[LO +: GROUP_W]));

    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_en[g] && $past(!latch_en[g]) && $past(dev_clk[g]) && !$past(dev_clk[g], 2)
       && $past(rst_n, 2) && drv_en[LO])
      |-> dout[LO +: GROUP_W] == $past(din[LO +: GROUP_W]));

    assert_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_en[g] && $past(latch_en[g]) && drv_en[LO])
      |-> dout[LO +: GROUP_W] == $past(din[LO +: GROUP_W]));
  end
endmodule

bind ubt_dir_reg ubt_dir_reg_chk #(.GROUP_W(GROUP_W), .NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_clk(dev_clk), .latch_en(latch_en), .oe_n(oe_n),
  .din(din), .dout(dout), .drv_en(drv_en)
);

// File: tb/ubt_dir_reg_bench.sv
module ubt_dir_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  dev_clk = 2'b10;
  logic [1:0]  latch_en = 2'b00;
  logic [1:0]  oe_n = 2'b11;
  logic [17:0] din = 18'h2AAAA;
  logic [17:0] dout;
  logic [17:0] drv_en;
  int          n_run = 0;
  int          n_fail = 0;

  localparam logic [17:0] X1 = 18'h0C3A5;
  localparam logic [17:0] Y  = 18'h2D1E5;
  localparam logic [17:0] WV = 18'h3A5C3;
  localparam logic [17:0] V  = 18'h15A96;

  always #10 clk = ~clk;

  ubt_dir_reg u_ubt_dir_reg (
    .clk(clk), .rst_n(rst_n), .dev_clk(dev_clk), .latch_en(latch_en),
    .oe_n(oe_n), .din(din), .dout(dout), .drv_en(drv_en)
  );

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic t_reset();
    tick(); tick();
    chk("R1 dout in reset", dout, 18'h0);
    chk("R1 drv_en in reset", drv_en, 18'h0);
    rst_n = 1'b1;
    oe_n  = 2'b00;
    tick();
    chk("R7 drive on", drv_en, 18'h3FFFF);
    tick();
    chk("R9 no capture from clock high at reset", dout, 18'h0);
  endtask

  task automatic t_transparent();
    latch_en = 2'b11;
    din = 18'h1234F; #1 chk("R2 pattern a", dout, 18'h1234F);
    din = 18'h3FFFF; #1 chk("R2 pattern b", dout, 18'h3FFFF);
    din = 18'h00000; #1 chk("R2 pattern c", dout, 18'h00000);
    din = 18'h15555; #1 chk("R2 pattern d", dout, 18'h15555);
    din = X1; tick();
    chk("R2 across edge", dout, X1);
  endtask

  task automatic t_close();
    latch_en = 2'b00;
    din = 18'h3F00F;
    #1 chk("R5 close keeps last transparent data", dout, X1);
    tick();
    chk("R5 after edge", dout, X1);
    din = 18'h00FF0; tick(); tick();
    chk("R3 hold with clocks static", dout, X1);
  endtask

  task automatic t_clocked();
    din = Y; dev_clk = 2'b11; tick();
    chk("R4 capture group0 R8 group1 kept", dout, {X1[17:9], Y[8:0]});
    din = 18'h1111F; tick();
    chk("R3 clock static high", dout, {X1[17:9], Y[8:0]});
    dev_clk = 2'b10; tick();
    chk("R6 falling group0", dout, {X1[17:9], Y[8:0]});
    dev_clk = 2'b00; tick();
    chk("R6 falling group1", dout, {X1[17:9], Y[8:0]});
    din = WV; dev_clk = 2'b10; tick();
    chk("R4 capture group1 R8 group0 kept", dout, {WV[17:9], Y[8:0]});
  endtask

  task automatic t_oe();
    oe_n = 2'b10; tick();
    chk("R7 drv off group1 only", drv_en, {9'h000, 9'h1FF});
    chk("R7 dout zero when off", dout, {9'h000, Y[8:0]});
    dev_clk = 2'b00; tick();
    din = V; dev_clk = 2'b10; tick();
    chk("R7 still off", dout, {9'h000, Y[8:0]});
    oe_n = 2'b00; tick();
    chk("R7 stored while off", dout, {V[17:9], Y[8:0]});
    chk("R7 drive back", drv_en, 18'h3FFFF);
    rst_n = 1'b0;
    #1 chk("R1 async reset dout", dout, 18'h0);
    chk("R1 async reset drv", drv_en, 18'h0);
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_close();
    t_clocked();
    t_oe();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule